// File: doc/BRIEF.md
# Latched Active-Address Output Port

One device in a cascade of lookup memories has to report an address together with its own page number. This block does that. For each completed cycle it selects one of three candidate addresses: the match address after a compare, the accessed location after a read or write, or the next-free location. It puts the device page number in front of that address and holds the combined word in a register. The word is loaded only while the active-low cycle strobe is HIGH and a cycle type is presented. It keeps its value through every cycle in which the strobe is LOW.

The drive decision is combinational, taken from the held word and the live control inputs. It models the tri-state output as a drive-enable. The port is driven only when the output enable is LOW. After a compare, the device also needs the grant from the external priority chain. The exception is a system-wide mismatch: then the device configured as lowest priority drives all ones. A status word reports the held value, the latched match, full and multiple-match flags, and a two-bit code for the cycle type that produced the value.

Top module: `aa_out_port`

## Requirements
- R1: A synchronous reset sets the held word to zero, the validation code to 00, all three status flags to 0 and the drive-enable to 0.
- R2: A clock edge with `cyc_en_n` HIGH and `cyc_kind` = 01 (compare) loads {`page_id`, `match_addr`} and sets the validation code to 01. The new value is visible after that edge.
- R3: A clock edge with `cyc_en_n` HIGH and `cyc_kind` = 10 (read/write) loads {`page_id`, `rw_addr`} and sets the validation code to 10.
- R4: A clock edge with `cyc_en_n` HIGH and `cyc_kind` = 11 (next-free) loads {`page_id`, `free_addr`} and sets the validation code to 11.
- R5: While `cyc_en_n` is LOW, the held word and validation code keep their values, whatever the cycle type, addresses and page.
- R6: With `cyc_en_n` HIGH and `cyc_kind` = 00, the held word and validation code keep their values.
- R7: While `oe_n` is HIGH, `out_drive` is 0.
- R8: With validation code 01, `out_drive` is 1 only if `oe_n` is LOW and either `prio_grant` is 1 or the mismatch condition of R9 holds. Without a grant or that condition, `out_drive` is 0 whatever `oe_n` is.
- R9: With validation code 01, `sys_miss` = 1 and `lowest_dev` = 1, `out_word` is all ones and `out_drive` follows `!oe_n`. Otherwise `out_word` equals the held word.
- R10: With validation code 10 or 11, `out_drive` equals `!oe_n`, independent of `prio_grant`.
- R11: `status_word` is {held word, match flag, full flag, multi flag, validation code}, with the code in bits [1:0]. Match and multi flags are loaded from `match_hit` and `multi_hit` on compare cycles. The full flag is loaded from `full_in` on read/write cycles. The flags hold otherwise.
- R12: With validation code 00, `out_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en_n | input | 1 | Active-low cycle strobe; loading allowed only while HIGH |
| cyc_kind | input | 2 | Cycle type: 00 none, 01 compare, 10 read/write, 11 next-free |
| page_id | input | PAGE_W | Device page number |
| match_addr | input | ADDR_W | Highest-priority match address from the array |
| free_addr | input | ADDR_W | Next-free address from the array |
| rw_addr | input | ADDR_W | Location accessed by a read or write |
| match_hit | input | 1 | Device has a match in the current compare |
| multi_hit | input | 1 | Multiple-match condition in the current compare |
| full_in | input | 1 | Device full after the current write |
| prio_grant | input | 1 | This device is the highest-priority responder |
| sys_miss | input | 1 | No device in the system matched |
| lowest_dev | input | 1 | Device is configured as lowest priority |
| oe_n | input | 1 | Active-low output enable |
| out_word | output | PAGE_W+ADDR_W | Page:address output value |
| out_drive | output | 1 | Drive-enable standing in for the tri-state control |
| status_word | output | PAGE_W+ADDR_W+5 | Held word, flags and validation code |

## Verification
Properties are evaluated on every clock. They cover the hold while the strobe is LOW or no cycle is given, loading of the compare code, the output enable forcing the drive off, no drive in the invalid state or without a grant after a compare, and the all-ones word whenever the mismatch substitution drives. The bench's scenarios cover what the properties leave open. These are the exact word loaded from each address source with its page prefix and the flag capture rules per cycle type. They also cover the switch between grant-controlled and enable-only driving as the cycle type changes, and the reset returning a used port to its invalid state.

// File: rtl/aa_out_pkg.sv
package aa_out_pkg;

    localparam int PAGE_W_DEF = 4;
    localparam int ADDR_W_DEF = 10;
    localparam int FLAG_W     = 3;
    localparam int VLD_W      = 2;

    // Cycle kind; the same code is stored as the validation code.
    typedef enum logic [1:0] {
        CYC_IDLE = 2'b00,
        CYC_CMP  = 2'b01,
        CYC_RW   = 2'b10,
        CYC_NFA  = 2'b11
    } cyc_e;

    typedef struct packed {
        logic mf;
        logic ff;
        logic mm;
    } flags_t;

    function automatic logic kind_loads(input logic en_n, input cyc_e k);
        return en_n && (k != CYC_IDLE);
    endfunction

endpackage

// File: rtl/aa_src_mux.sv
module aa_src_mux
    import aa_out_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  cyc_e              kind,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [ADDR_W-1:0] rw_addr,
    output logic [ADDR_W-1:0] sel_addr
);

    always_comb begin
        unique case (kind)
            CYC_CMP: sel_addr = match_addr;
            CYC_RW:  sel_addr = rw_addr;
            CYC_NFA: sel_addr = free_addr;
            default: sel_addr = '0;
        endcase
    end

endmodule

// File: rtl/aa_hold_reg.sv
module aa_hold_reg
    import aa_out_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    localparam int WORD_W = PAGE_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en_n,
    input  cyc_e              kind,
    input  logic [PAGE_W-1:0] page_id,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              match_hit,
    input  logic              multi_hit,
    input  logic              full_in,
    output logic [WORD_W-1:0] word_q,
    output cyc_e              vld_q,
    output flags_t            flags_q
);

    logic load;
    assign load = kind_loads(cyc_en_n, kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            vld_q   <= CYC_IDLE;
            flags_q <= '0;
        end else if (load) begin
            word_q <= {page_id, sel_addr};
            vld_q  <= kind;
            if (kind == CYC_CMP) begin
                flags_q.mf <= match_hit;
                flags_q.mm <= multi_hit;
            end
            if (kind == CYC_RW) begin
                flags_q.ff <= full_in;
            end
        end
    end

    // R5
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_en_n |=> ($stable(word_q) && $stable(vld_q)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en_n && kind == CYC_IDLE) |=> ($stable(word_q) && $stable(flags_q)));

    // R2
    cmp_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_en_n && kind == CYC_CMP) |=> (vld_q == CYC_CMP));

endmodule

// File: rtl/aa_drive_ctl.sv
module aa_drive_ctl
    import aa_out_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    localparam int WORD_W = PAGE_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_q,
    input  cyc_e              vld_q,
    input  logic              oe_n,
    input  logic              prio_grant,
    input  logic              sys_miss,
    input  logic              lowest_dev,
    output logic [WORD_W-1:0] out_word,
    output logic              out_drive
);

    logic miss_sub;
    logic may_drive;

    always_comb begin
        miss_sub = (vld_q == CYC_CMP) && sys_miss && lowest_dev;
        unique case (vld_q)
            CYC_CMP:         may_drive = prio_grant || miss_sub;
            CYC_RW, CYC_NFA: may_drive = 1'b1;
            default:         may_drive = 1'b0;
        endcase
        out_drive = !oe_n && may_drive;
        out_word  = miss_sub ? {WORD_W{1'b1}} : word_q;
    end

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !out_drive);

    // R12
    no_drive_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q == CYC_IDLE) |-> !out_drive);

    // R8
    grant_needed_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q == CYC_CMP && !prio_grant && !(sys_miss && lowest_dev)) |-> !out_drive);

    // R9
    miss_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (out_drive && vld_q == CYC_CMP && !prio_grant) |-> (&out_word));

endmodule

// File: rtl/aa_out_port.sv
module aa_out_port
    import aa_out_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    localparam int WORD_W = PAGE_W + ADDR_W,
    localparam int STAT_W = WORD_W + FLAG_W + VLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en_n,
    input  logic [1:0]        cyc_kind,
    input  logic [PAGE_W-1:0] page_id,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic [ADDR_W-1:0] rw_addr,
    input  logic              match_hit,
    input  logic              multi_hit,
    input  logic              full_in,
    input  logic              prio_grant,
    input  logic              sys_miss,
    input  logic              lowest_dev,
    input  logic              oe_n,
    output logic [WORD_W-1:0] out_word,
    output logic              out_drive,
    output logic [STAT_W-1:0] status_word
);

    cyc_e              kind;
    logic [ADDR_W-1:0] sel_addr;
    logic [WORD_W-1:0] word_q;
    cyc_e              vld_q;
    flags_t            flags_q;

    assign kind = cyc_e'(cyc_kind);

    aa_src_mux #(.ADDR_W(ADDR_W)) u_mux (
        .kind       (kind),
        .match_addr (match_addr),
        .free_addr  (free_addr),
        .rw_addr    (rw_addr),
        .sel_addr   (sel_addr)
    );

    aa_hold_reg #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cyc_en_n  (cyc_en_n),
        .kind      (kind),
        .page_id   (page_id),
        .sel_addr  (sel_addr),
        .match_hit (match_hit),
        .multi_hit (multi_hit),
        .full_in   (full_in),
        .word_q    (word_q),
        .vld_q     (vld_q),
        .flags_q   (flags_q)
    );

    aa_drive_ctl #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_drv (
        .clk        (clk),
        .rst        (rst),
        .word_q     (word_q),
        .vld_q      (vld_q),
        .oe_n       (oe_n),
        .prio_grant (prio_grant),
        .sys_miss   (sys_miss),
        .lowest_dev (lowest_dev),
        .out_word   (out_word),
        .out_drive  (out_drive)
    );

    assign status_word = {word_q, flags_q.mf, flags_q.ff, flags_q.mm, vld_q};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status_word == '0 && !out_drive));

endmodule

// File: tb/tb_aa_out_port.sv
module tb_aa_out_port;

    localparam int PW = 4;
    localparam int AW = 10;
    localparam int WW = PW + AW;
    localparam int SW = WW + 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc_en_n = 1'b0;
    logic [1:0]    cyc_kind = 2'b00;
    logic [PW-1:0] page_id = '0;
    logic [AW-1:0] match_addr = '0, free_addr = '0, rw_addr = '0;
    logic          match_hit = 0, multi_hit = 0, full_in = 0;
    logic          prio_grant = 0, sys_miss = 0, lowest_dev = 0, oe_n = 1;
    logic [WW-1:0] out_word;
    logic          out_drive;
    logic [SW-1:0] status_word;

    always #10 clk = ~clk;

    aa_out_port #(.PAGE_W(PW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .cyc_en_n(cyc_en_n), .cyc_kind(cyc_kind),
        .page_id(page_id), .match_addr(match_addr), .free_addr(free_addr),
        .rw_addr(rw_addr), .match_hit(match_hit), .multi_hit(multi_hit),
        .full_in(full_in), .prio_grant(prio_grant), .sys_miss(sys_miss),
        .lowest_dev(lowest_dev), .oe_n(oe_n), .out_word(out_word),
        .out_drive(out_drive), .status_word(status_word)
    );

    typedef struct {
        int            req;
        logic [WW-1:0] w;
        logic          d;
        logic [SW-1:0] st;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    // reference state, built from the requirements
    logic [WW-1:0] m_word;
    logic [1:0]    m_vld;
    logic          m_mf, m_ff, m_mm;

    // monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (out_word !== e.w || out_drive !== e.d || status_word !== e.st) begin
                    bad++;
                    $display("FAIL R%0d: word=%h drive=%b status=%h expected word=%h drive=%b status=%h",
                             e.req, out_word, out_drive, status_word, e.w, e.d, e.st);
                end
            end
        end
    end

    // driver: inputs are already set; model the edge and queue the expectation
    task automatic step(input int req);
        exp_t e;
        logic miss, may;
        if (rst) begin
            m_word = '0; m_vld = 2'b00; m_mf = 0; m_ff = 0; m_mm = 0;  // R1
        end else if (cyc_en_n && cyc_kind != 2'b00) begin
            case (cyc_kind)
                2'b01: m_word = {page_id, match_addr};  // R2
                2'b10: m_word = {page_id, rw_addr};     // R3
                default: m_word = {page_id, free_addr}; // R4
            endcase
            m_vld = cyc_kind;
            if (cyc_kind == 2'b01) begin m_mf = match_hit; m_mm = multi_hit; end  // R11
            if (cyc_kind == 2'b10) m_ff = full_in;
        end
        miss = (m_vld == 2'b01) && sys_miss && lowest_dev;
        may  = (m_vld == 2'b01) ? (prio_grant || miss) : (m_vld != 2'b00);
        e.req = req;
        e.w   = miss ? '1 : m_word;
        e.d   = !oe_n && may;
        e.st  = {m_word, m_mf, m_ff, m_mm, m_vld};
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic cyc(input logic [1:0] k, input int req);
        cyc_en_n = 1'b1; cyc_kind = k;
        step(req);
        cyc_en_n = 1'b0; cyc_kind = 2'b00;
    endtask

    initial begin
        @(negedge clk);
        oe_n = 0; prio_grant = 1;
        step(1);                         // R1 reset state, R12 no drive when invalid
        rst = 0;
        step(12);                        // R12 invalid code keeps the port off
        page_id = 4'hA; match_addr = 10'h123; match_hit = 1; multi_hit = 0;
        oe_n = 1; prio_grant = 0;
        cyc(2'b01, 2);                   // R2 compare load, R7 oe high
        oe_n = 0;
        step(8);                         // R8 no grant, no drive
        prio_grant = 1;
        step(8);                         // R8 grant drives
        match_addr = 10'h2AA; rw_addr = 10'h011; page_id = 4'h5; cyc_kind = 2'b10;
        step(5);                         // R5 strobe low holds
        step(5);
        cyc_en_n = 1; cyc_kind = 2'b00;
        step(6);                         // R6 idle holds
        cyc_en_n = 0;
        page_id = 4'h3; rw_addr = 10'h3FE; full_in = 1; prio_grant = 0; match_hit = 0;
        cyc(2'b10, 3);                   // R3 read/write, R10 no grant needed, R11 flags
        free_addr = 10'h005; full_in = 0;
        cyc(2'b11, 4);                   // R4 next-free, R11 full flag held
        step(10);                        // R10
        oe_n = 1;
        step(7);                         // R7
        oe_n = 0; sys_miss = 1; lowest_dev = 1; match_addr = 10'h0F0; multi_hit = 1;
        cyc(2'b01, 9);                   // R9 all ones from lowest device
        lowest_dev = 0;
        step(9);                         // R9 not lowest: held word, no drive
        lowest_dev = 1; oe_n = 1;
        step(7);                         // R7 over mismatch substitution
        oe_n = 0; sys_miss = 0; prio_grant = 1;
        step(11);                        // R11 status after compare
        full_in = 1;
        cyc(2'b11, 11);                  // R11 next-free leaves the flags alone
        rst = 1;
        step(1);                         // R1 reset after use
        rst = 0;
        step(12);
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule